// File: doc/BRIEF.md
# Two-Dimensional Receive Eye Centering Trainer

This block finds a good receive sampling point for a single data lane. After a start pulse it steps through every delay tap at one reference-voltage code, then moves to the next code, and repeats until the requested code range is done. At each (tap, code) point it raises a one-cycle probe. An external pattern checker compares a repeating alternating training word (0x55) against what the lane received, then answers with a pass/fail bit and a valid strobe. The trainer holds the point steady until that answer arrives.

For each code, the trainer keeps the first run of passing taps. That run is bounded by the failing tap just below it and the failing tap just above it; a tap past either end of the delay line counts as failing. The centre of the run goes into a per-code table. When the sweep is over, the trained reference code is the midpoint of the lowest and highest codes that had a window. The trained delay is the centre stored for that code. If no point passed, an error flag is raised instead.

The voltage sweep can be turned off, so only one code is trained. A range-select bit is taken at start. It travels with the code during the sweep and is returned with the trained result, because it is part of the value the lane is finally programmed with.

Top module: `eye_centre_trainer`

## Requirements
- R1: After reset, probe, done, trn_err, trn_dly, trn_vref and trn_rng are all 0.
- R2: After start, the trainer issues exactly one probe per point. Codes run upward from vref_min to the last code, and within each code the taps run 0 to 2^TAP_W-1. The last code is vref_max when sweep_en is 1 and vref_max > vref_min; otherwise it is vref_min.
- R3: dly_tap and vref_code stay unchanged from a probe until the chk_valid answer for that probe is taken.
- R4: For each code, the window is the first contiguous run of passing taps. Its edges are the failing taps on either side, and a tap beyond tap 0 or the top tap counts as failing. The row centre is floor((first pass + last pass)/2). Passing taps after the first run has closed are ignored.
- R5: trn_vref is floor((lowest code with a window + highest code with a window)/2).
- R6: trn_dly is the row centre of the code given as trn_vref. If the midpoint code has no window, the nearest lower code that has one is used for both trn_vref and trn_dly.
- R7: If no point in the sweep passes, trn_err is 1 and trn_dly, trn_vref and trn_rng are 0. Otherwise trn_err is 0.
- R8: range_sel is latched at start. It is driven on vref_rng throughout the sweep and returned as trn_rng.
- R9: done is a single-cycle pulse, and the trained outputs are valid in that cycle. A start pulse, or a change to the setup inputs, while a sweep is running has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a training sweep (accepted only when idle) |
| sweep_en | input | 1 | 1: sweep codes vref_min..vref_max; 0: train at vref_min only |
| vref_min | input | VREF_W | First reference code of the sweep |
| vref_max | input | VREF_W | Last reference code of the sweep |
| range_sel | input | 1 | Reference range select, latched at start |
| probe | output | 1 | One-cycle request to test the current point |
| dly_tap | output | TAP_W | Delay tap under test |
| vref_code | output | VREF_W | Reference code under test |
| vref_rng | output | 1 | Range select under test |
| chk_valid | input | 1 | Checker answer strobe |
| chk_pass | input | 1 | Checker result: 1 = pattern matched |
| done | output | 1 | One-cycle completion pulse |
| trn_err | output | 1 | No passing point was found |
| trn_dly | output | TAP_W | Trained delay tap |
| trn_vref | output | VREF_W | Trained reference code |
| trn_rng | output | 1 | Trained range select |

## Verification
The assertions assume the checker returns exactly one chk_valid for each probe, and only after that probe. They also assume chk_valid never arrives in the same cycle as its probe. Under those conditions they can rely on the point staying stable across the wait, and on the sweep order and the single-cycle done. The bench checker model waits at least one cycle after each probe, waits a random 1 to 4 cycles, then gives one answer and nothing else. The pass/fail eye it answers from is a bitmap: random diamond-shaped openings plus directed shapes for empty eyes, rows that run to either end of the delay line, split windows and a hole at the centre code.

// File: rtl/eye_train_pkg.sv
// Package: shared state encoding and the rounding-down midpoint used by the
// eye centering trainer. Assumes operands fit in 16 bits.
package eye_train_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_WAIT,
        ST_ROWEND,
        ST_CENTRE,
        ST_FIND,
        ST_DONE
    } train_st_e;

    // Midpoint of two unsigned values, rounded toward the lower value.
    function automatic logic [15:0] mid_floor(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[16:1];
    endfunction

endpackage

// File: rtl/eye_row_tracker.sv
// Row window tracker: follows one sweep of delay taps at a fixed reference
// code and keeps the first contiguous run of passing taps. Assumes taps are
// presented in increasing order and that clr is raised before each new row.
module eye_row_tracker #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             have,
    output logic [TAP_W-1:0] lo,
    output logic [TAP_W-1:0] hi
);

    logic closed;

    // Track the first run of passes; a fail after a pass closes the run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have   <= 1'b0;
            closed <= 1'b0;
            lo     <= '0;
            hi     <= '0;
        end else if (smp && !closed) begin
            if (pass) begin
                if (!have) begin
                    lo <= tap;
                end
                hi   <= tap;
                have <= 1'b1;
            end else if (have) begin
                closed <= 1'b1;
            end
        end
    end

    // Window bounds never cross each other.
    assert_window_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        have |-> (lo <= hi));

    // Once the run is closed, no further pass may move its upper bound.
    assert_run_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !clr) |=> $stable(hi));

endmodule

// File: rtl/eye_centre_store.sv
// Per-code result table: one entry per reference code, holding a flag that
// the row had a window and the centre tap of that window. Written once per
// row, read combinationally during the final search.
module eye_centre_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              ent_vld [DEPTH];
    logic [DATA_W-1:0] ent_cen [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Capture the row result addressed to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[i] <= 1'b0;
                ent_cen[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                ent_vld[i] <= wr_valid;
                ent_cen[i] <= wr_data;
            end
        end
    end

    // Read port for the centre search.
    always_comb begin
        rd_valid = ent_vld[rd_addr];
        rd_data  = ent_cen[rd_addr];
    end

endmodule

// File: rtl/eye_centre_trainer.sv
// Two-dimensional receive eye centering trainer. Sweeps delay taps inside
// reference codes, asks an external checker for a pass/fail verdict at each
// point, and reports the centre of the passing region. Assumes the checker
// answers each probe exactly once and no earlier than the cycle after it.
module eye_centre_trainer
    import eye_train_pkg::*;
#(
    parameter int TAP_W  = 5,
    parameter int VREF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sweep_en,
    input  logic [VREF_W-1:0] vref_min,
    input  logic [VREF_W-1:0] vref_max,
    input  logic              range_sel,
    output logic              probe,
    output logic [TAP_W-1:0]  dly_tap,
    output logic [VREF_W-1:0] vref_code,
    output logic              vref_rng,
    input  logic              chk_valid,
    input  logic              chk_pass,
    output logic              done,
    output logic              trn_err,
    output logic [TAP_W-1:0]  trn_dly,
    output logic [VREF_W-1:0] trn_vref,
    output logic              trn_rng
);

    localparam logic [TAP_W-1:0] TAP_LAST = {TAP_W{1'b1}};

    train_st_e         st;
    logic [TAP_W-1:0]  cur_d;
    logic [VREF_W-1:0] cur_v;
    logic [VREF_W-1:0] v_last;
    logic              rng_q;
    logic              any_q;
    logic [VREF_W-1:0] vlo_q;
    logic [VREF_W-1:0] vhi_q;
    logic [VREF_W-1:0] look;

    logic              row_clr;
    logic              row_smp;
    logic              row_have;
    logic [TAP_W-1:0]  row_lo;
    logic [TAP_W-1:0]  row_hi;
    logic [TAP_W-1:0]  row_cen;
    logic [VREF_W-1:0] v_mid;
    logic              rd_valid;
    logic [TAP_W-1:0]  rd_data;
    logic [15:0]       row_mid16;
    logic [15:0]       v_mid16;

    // Drive the point under test and the status pulses from the state.
    always_comb begin
        probe     = (st == ST_PROBE);
        done      = (st == ST_DONE);
        dly_tap   = cur_d;
        vref_code = cur_v;
        vref_rng  = rng_q;
        row_clr   = ((st == ST_IDLE) && start) || (st == ST_ROWEND);
        row_smp   = (st == ST_WAIT) && chk_valid;
    end

    // Centre of the current row and centre of the passing code range.
    always_comb begin
        row_mid16 = mid_floor(16'(row_lo), 16'(row_hi));
        v_mid16   = mid_floor(16'(vlo_q), 16'(vhi_q));
        row_cen   = row_mid16[TAP_W-1:0];
        v_mid     = v_mid16[VREF_W-1:0];
    end

    eye_row_tracker #(.TAP_W(TAP_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (row_clr),
        .smp   (row_smp),
        .pass  (chk_pass),
        .tap   (cur_d),
        .have  (row_have),
        .lo    (row_lo),
        .hi    (row_hi)
    );

    eye_centre_store #(.ADDR_W(VREF_W), .DATA_W(TAP_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st == ST_ROWEND),
        .wr_addr  (cur_v),
        .wr_valid (row_have),
        .wr_data  (row_cen),
        .rd_addr  (look),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Sweep sequencer, range bookkeeping and final centre search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_d    <= '0;
            cur_v    <= '0;
            v_last   <= '0;
            rng_q    <= 1'b0;
            any_q    <= 1'b0;
            vlo_q    <= '0;
            vhi_q    <= '0;
            look     <= '0;
            trn_err  <= 1'b0;
            trn_dly  <= '0;
            trn_vref <= '0;
            trn_rng  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur_d  <= '0;
                        cur_v  <= vref_min;
                        v_last <= (sweep_en && (vref_max > vref_min)) ? vref_max : vref_min;
                        rng_q  <= range_sel;
                        any_q  <= 1'b0;
                        st     <= ST_PROBE;
                    end
                end
                ST_PROBE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (chk_valid) begin
                        if (cur_d == TAP_LAST) begin
                            st <= ST_ROWEND;
                        end else begin
                            cur_d <= cur_d + 1'b1;
                            st    <= ST_PROBE;
                        end
                    end
                end
                ST_ROWEND: begin
                    if (row_have) begin
                        if (!any_q) begin
                            vlo_q <= cur_v;
                        end
                        vhi_q <= cur_v;
                        any_q <= 1'b1;
                    end
                    if (cur_v == v_last) begin
                        st <= ST_CENTRE;
                    end else begin
                        cur_v <= cur_v + 1'b1;
                        cur_d <= '0;
                        st    <= ST_PROBE;
                    end
                end
                ST_CENTRE: begin
                    if (!any_q) begin
                        trn_err  <= 1'b1;
                        trn_dly  <= '0;
                        trn_vref <= '0;
                        trn_rng  <= 1'b0;
                        st       <= ST_DONE;
                    end else begin
                        look <= v_mid;
                        st   <= ST_FIND;
                    end
                end
                ST_FIND: begin
                    if (rd_valid) begin
                        trn_err  <= 1'b0;
                        trn_dly  <= rd_data;
                        trn_vref <= look;
                        trn_rng  <= rng_q;
                        st       <= ST_DONE;
                    end else begin
                        look <= look - 1'b1;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // The point under test holds while the checker works on it.
    assert_point_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> ($stable(dly_tap) && $stable(vref_code)));

    // A probe is never repeated back to back: one request per point.
    assert_single_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        probe |=> !probe);

    // The range select cannot move in the middle of a point.
    assert_range_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> $stable(vref_rng));

    // Completion lasts exactly one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An error result carries no trained values.
    assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trn_err |-> (trn_dly == '0 && trn_vref == '0 && !trn_rng));

    // The downward search never walks below the lowest passing code.
    assert_search_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIND) |-> (look >= vlo_q && look <= vhi_q));

endmodule

// File: tb/tb_eye_centre_trainer.sv
`timescale 1ns/1ps
module tb_eye_centre_trainer;

    localparam int TAP_W  = 5;
    localparam int VREF_W = 6;
    localparam int NTAP   = 1 << TAP_W;
    localparam int NV     = 1 << VREF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              sweep_en = 1'b0;
    logic [VREF_W-1:0] vref_min = '0;
    logic [VREF_W-1:0] vref_max = '0;
    logic              range_sel = 1'b0;
    logic              probe;
    logic [TAP_W-1:0]  dly_tap;
    logic [VREF_W-1:0] vref_code;
    logic              vref_rng;
    logic              chk_valid = 1'b0;
    logic              chk_pass = 1'b0;
    logic              done;
    logic              trn_err;
    logic [TAP_W-1:0]  trn_dly;
    logic [VREF_W-1:0] trn_vref;
    logic              trn_rng;

    eye_centre_trainer #(.TAP_W(TAP_W), .VREF_W(VREF_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sweep_en(sweep_en),
        .vref_min(vref_min), .vref_max(vref_max), .range_sel(range_sel),
        .probe(probe), .dly_tap(dly_tap), .vref_code(vref_code), .vref_rng(vref_rng),
        .chk_valid(chk_valid), .chk_pass(chk_pass), .done(done), .trn_err(trn_err),
        .trn_dly(trn_dly), .trn_vref(trn_vref), .trn_rng(trn_rng)
    );

    always #5 clk = ~clk;

    logic [NTAP-1:0] emap [NV];
    int total = 0;
    int fails = 0;
    int n_probe, order_err, stab_err, rng_err;
    int exp_d, exp_v, exp_rng_bit;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_map();
        for (int v = 0; v < NV; v++) emap[v] = '0;
    endtask

    // Diamond-shaped opening centred at (cd, vc).
    task automatic diamond(input int vc, input int cd, input int hw, input int vr);
        for (int v = vc - vr; v <= vc + vr; v++) begin
            int w;
            if (v < 0 || v >= NV) continue;
            w = hw - ((v > vc) ? v - vc : vc - v);
            for (int d = cd - w; d <= cd + w; d++)
                if (d >= 0 && d < NTAP) emap[v][d] = 1'b1;
        end
    endtask

    task automatic set_run(input int v, input int a, input int b);
        for (int d = a; d <= b; d++) emap[v][d] = 1'b1;
    endtask

    // Checker model: answers each probe once, 1..4 cycles later.
    initial begin
        forever begin
            @(negedge clk);
            chk_valid = 1'b0;
            if (probe) begin
                int pd, pv, lat;
                pd = int'(dly_tap);
                pv = int'(vref_code);
                n_probe++;
                if (pd != exp_d || pv != exp_v) order_err++;
                if (vref_rng != exp_rng_bit[0]) rng_err++;
                exp_d++;
                if (exp_d == NTAP) begin exp_d = 0; exp_v++; end
                lat = 1 + int'($urandom % 4);
                repeat (lat) @(negedge clk);
                if (int'(dly_tap) != pd || int'(vref_code) != pv) stab_err++;
                chk_pass  = emap[pv][pd];
                chk_valid = 1'b1;
            end
        end
    end

    // Bench model of the expected result, derived from the requirements.
    task automatic expect_run(input int en, input int vmin, input int vmax, input int rng,
                              output int rows, output int e_err, output int e_dly,
                              output int e_vref, output int e_rng);
        int vlast, lo_v, hi_v, vc;
        bit any;
        bit have [NV];
        int cen [NV];
        vlast = (en != 0 && vmax > vmin) ? vmax : vmin;
        rows = vlast - vmin + 1;
        any = 0; lo_v = 0; hi_v = 0;
        for (int v = 0; v < NV; v++) begin have[v] = 0; cen[v] = 0; end
        for (int v = vmin; v <= vlast; v++) begin
            bit seen, closed;
            int a, b;
            seen = 0; closed = 0; a = 0; b = 0;
            for (int d = 0; d < NTAP; d++) begin
                if (closed) continue;
                if (emap[v][d]) begin
                    if (!seen) a = d;
                    seen = 1; b = d;
                end else if (seen) closed = 1;
            end
            have[v] = seen;
            cen[v] = (a + b) / 2;
            if (seen) begin
                if (!any) lo_v = v;
                hi_v = v; any = 1;
            end
        end
        if (!any) begin
            e_err = 1; e_dly = 0; e_vref = 0; e_rng = 0;
        end else begin
            vc = (lo_v + hi_v) / 2;
            while (!have[vc]) vc--;
            e_err = 0; e_dly = cen[vc]; e_vref = vc; e_rng = rng;
        end
    endtask

    task automatic run(input string tag, input int en, input int vmin, input int vmax,
                       input int rng);
        int rows, e_err, e_dly, e_vref, e_rng, cyc;
        expect_run(en, vmin, vmax, rng, rows, e_err, e_dly, e_vref, e_rng);
        @(negedge clk);
        n_probe = 0; order_err = 0; stab_err = 0; rng_err = 0;
        exp_d = 0; exp_v = vmin; exp_rng_bit = rng;
        sweep_en = en[0]; vref_min = VREF_W'(vmin); vref_max = VREF_W'(vmax);
        range_sel = rng[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: setup changes and a second start mid-sweep must be ignored.
        repeat (7) @(negedge clk);
        vref_min = VREF_W'($urandom); vref_max = VREF_W'($urandom);
        sweep_en = ~sweep_en; range_sel = ~range_sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        $display("run %s: rows=%0d err=%0d dly=%0d vref=%0d", tag, rows, e_err, e_dly, e_vref);
        chk({"R9 done seen ", tag}, int'(done), 1);
        chk({"R7 trn_err ", tag}, int'(trn_err), e_err);
        chk({"R4/R6 trn_dly ", tag}, int'(trn_dly), e_dly);
        chk({"R5/R6 trn_vref ", tag}, int'(trn_vref), e_vref);
        chk({"R8 trn_rng ", tag}, int'(trn_rng), e_rng);
        chk({"R2 probe count ", tag}, n_probe, rows * NTAP);
        chk({"R2 probe order ", tag}, order_err, 0);
        chk({"R3 point stable ", tag}, stab_err, 0);
        chk({"R8 vref_rng in sweep ", tag}, rng_err, 0);
        @(negedge clk);
        chk({"R9 done one cycle ", tag}, int'(done), 0);
        repeat (3) @(negedge clk);
        chk({"R2 no stray probe ", tag}, n_probe, rows * NTAP);
    endtask

    initial begin
        #(1900000);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_map();
        exp_d = 0; exp_v = 0; exp_rng_bit = 0;
        n_probe = 0; order_err = 0; stab_err = 0; rng_err = 0;
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk("R1 probe", int'(probe), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 trn_err", int'(trn_err), 0);
        chk("R1 trn_dly", int'(trn_dly), 0);
        chk("R1 trn_vref", int'(trn_vref), 0);
        chk("R1 trn_rng", int'(trn_rng), 0);
        rst_n = 1'b1;

        // R7: nothing passes.
        clear_map();
        run("empty", 1, 20, 24, 1);

        // R4: single code, row opens at tap 0 and closes at the top tap.
        clear_map(); set_run(9, 0, NTAP - 1);
        run("full row", 0, 9, 40, 1);

        // R4: second passing run after a closed window is ignored.
        clear_map(); set_run(30, 3, 6); set_run(30, 20, 25);
        run("split row", 0, 30, 30, 0);

        // R4: single passing point.
        clear_map(); set_run(5, 17, 17);
        run("single point", 1, 2, 7, 1);

        // R6: hole at the midpoint code falls back to the nearest lower code.
        clear_map();
        set_run(10, 4, 8); set_run(11, 12, 20); set_run(13, 1, 2); set_run(14, 22, 30);
        run("centre hole", 1, 9, 15, 0);

        // R2: vref_max below vref_min gives a single-code sweep.
        clear_map(); diamond(50, 16, 8, 3);
        run("max below min", 1, 50, 45, 1);

        // Random diamond eyes.
        for (int i = 0; i < 6; i++) begin
            int vc, cd, hw, vr, vmin, span;
            clear_map();
            vc = 5 + int'($urandom % 50);
            cd = int'($urandom % NTAP);
            hw = 2 + int'($urandom % 10);
            vr = int'($urandom % 5);
            diamond(vc, cd, hw, vr);
            if ($urandom % 2) diamond(vc + 2, (cd + 7) % NTAP, 2, 1);
            vmin = vc - 3 - int'($urandom % 3);
            span = 4 + int'($urandom % 6);
            run($sformatf("random%0d", i), 1, vmin, vmin + span, int'($urandom % 2));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule